// File: doc/BRIEF.md
# Software-Driven Serial Shift Engine

This block is a small serial engine that a host processor drives. One 8-bit shift register carries both the byte going out and the byte coming in. The host loads and reads it directly. Each shift takes the data-input pin into bit 0 and moves the register one place toward the most significant bit, so bytes go out and come in MSB first. The serial output does not come straight from bit 7. It passes through a holding flop that changes only on the clock edge opposite the sampling edge, so the output has half a clock period to settle before the far end samples it.

A 4-bit edge counter counts every shift-clock edge, both sampling and updating edges. Sixteen edges move one byte. On the sixteenth edge the counter wraps to zero, the finished byte is copied into a buffer register and an overflow flag is set. The flag raises an interrupt when the interrupt is enabled. The shift clock can come from four sources: a software strobe, a timer compare pulse, or the external clock pin with either polarity.

A line-mode input chooses between off, three-wire operation (separate data out, data in and clock) and two-wire operation. In two-wire mode the data and clock lines are open-drain: they are pulled low for a 0 and released for a 1. The clock-phase state machine has three states. PH_OFF holds the clock output low. PH_LOW means the clock output is low and the next internal event is a sampling edge. PH_HIGH means the clock output is high and the next internal event is an update edge. The machine moves PH_OFF→PH_LOW when the engine is enabled. It moves PH_LOW→PH_HIGH and PH_HIGH→PH_LOW on each internal clock event, or on a software toggle when the clock is external. Every state returns to PH_OFF when the line mode is off.

Top module: `ser_shift_unit`

## Requirements
- R1: A one-cycle pulse on `dat_wr` loads `dat_wdata` into the shift register, where it can be read on `dat_q` after the next clock edge. The same write sets the serial output bit to `dat_wdata[7]`. A write wins over a shift in the same cycle.
- R2: On every sampling edge the shift register moves left by one place and takes the synchronised `di_in` into bit 0. After eight sampling edges `dat_q` holds the received byte, with the first bit received in bit 7.
- R3: The serial output bit changes only on an update edge (where it takes bit 7 of the shift register) or on a host write. A sampling edge leaves it unchanged.
- R4: `clk_src` chooses the clock source. The encodings are: 0 = `sw_strobe`, 1 = `tmr_tick`, 2 = external pin with rising edge sampling, 3 = external pin with falling edge sampling. With an internal source (0 or 1), each event flips the clock output; a low-to-high flip is a sampling edge and a high-to-low flip is an update edge. A pulse from the source that is not selected has no effect.
- R5: `edge_cnt` advances by one on every sampling or update edge. The sixteenth edge wraps it from 15 to 0, copies the completed byte into `buf_q` and sets `ovf_flag`. `buf_q` changes at no other time.
- R6: `irq` equals `ovf_flag` AND `irq_en`. A one-cycle pulse on `flag_clr` clears the flag. If a wrap and a clear fall in the same cycle, the flag is set.
- R7: The line-mode encodings are: `wire_mode` 0 = off, 1 = three-wire, 2 or 3 = two-wire. While the mode is off, clock events are ignored, `edge_cnt` is held at 0, the clock output is low, `do_o` is 1, both pull-low outputs are 0, and the shift register, buffer and flag keep their values.
- R8: In three-wire mode `do_o` carries the serial output bit, `sck_o` carries the clock output, and neither pull-low output is asserted. In two-wire mode `sda_pull_low` is 1 exactly when the serial output bit is 0, `scl_pull_low` is 1 exactly when the clock output is low, `do_o` is 1 and `sck_o` is 0.
- R9: With an external clock source (2 or 3), a `sw_toggle` pulse inverts the clock output and does not count as an edge. With an internal source, `sw_toggle` has no effect.
- R10: Serial data is always sampled from `di_in`, in two-wire mode as well as in three-wire mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wire_mode | input | 2 | Line mode: 0 off, 1 three-wire, 2/3 two-wire |
| clk_src | input | 2 | Shift clock source: 0 strobe, 1 timer, 2 pin rising, 3 pin falling |
| irq_en | input | 1 | Overflow interrupt enable |
| dat_wr | input | 1 | Host write strobe for the shift register |
| dat_wdata | input | 8 | Host write data |
| flag_clr | input | 1 | Write-one-to-clear pulse for the overflow flag |
| sw_strobe | input | 1 | Software clock event |
| sw_toggle | input | 1 | Inverts the clock output when the clock source is external |
| tmr_tick | input | 1 | Timer compare-match event |
| sck_in | input | 1 | External clock pin |
| di_in | input | 1 | Serial data-in pin |
| dat_q | output | 8 | Shift register contents |
| buf_q | output | 8 | Last completed byte |
| edge_cnt | output | 4 | Edge counter |
| ovf_flag | output | 1 | Counter overflow flag |
| irq | output | 1 | Overflow interrupt |
| do_o | output | 1 | Three-wire serial data out |
| sck_o | output | 1 | Three-wire clock out |
| sda_pull_low | output | 1 | Two-wire data line pull-low enable |
| scl_pull_low | output | 1 | Two-wire clock line pull-low enable |

## Verification
The assertions assume that the clock source does not change while the engine is enabled. They also assume that the external clock pin has settled through its synchroniser before the mode turns on, so reconfiguring never produces a false edge. The bench changes `clk_src` and presets `sck_in` to its idle level only while `wire_mode` is 0, and waits several cycles before enabling. It holds `di_in` stable for several cycles before each sampling edge and spaces clock events far enough apart that each one is seen as a single edge.

// File: rtl/ser_shift_pkg.sv
package ser_shift_pkg;
    typedef enum logic [1:0] {
        SRC_SOFT     = 2'd0,
        SRC_TIMER    = 2'd1,
        SRC_EXT_RISE = 2'd2,
        SRC_EXT_FALL = 2'd3
    } clk_src_e;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;
endpackage

// File: rtl/ser_clk_phase.sv
module ser_clk_phase
    import ser_shift_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] src,
    input  logic       sw_strobe,
    input  logic       tmr_tick,
    input  logic       sw_toggle,
    input  logic       sck_pin,
    input  logic       di_pin,
    output logic       smp_ev,
    output logic       upd_ev,
    output logic       clk_level,
    output logic       di_s
);
    logic [SYNC_STAGES-1:0] sck_sy;
    logic [SYNC_STAGES-1:0] di_sy;
    logic                   sck_prev;
    logic                   sck_now;
    logic                   ext_rise;
    logic                   ext_fall;
    logic                   is_int;
    logic                   int_ev;
    logic                   flip;
    phase_e                 state_q;
    phase_e                 state_d;

    // input synchronisers and edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_sy   <= '0;
            di_sy    <= '0;
            sck_prev <= 1'b0;
        end else begin
            sck_sy   <= {sck_sy[SYNC_STAGES-2:0], sck_pin};
            di_sy    <= {di_sy[SYNC_STAGES-2:0], di_pin};
            sck_prev <= sck_now;
        end
    end

    assign sck_now  = sck_sy[SYNC_STAGES-1];
    assign di_s     = di_sy[SYNC_STAGES-1];
    assign ext_rise = sck_now & ~sck_prev;
    assign ext_fall = ~sck_now & sck_prev;
    assign is_int   = (src == SRC_SOFT) || (src == SRC_TIMER);
    assign int_ev   = en && is_int && ((src == SRC_SOFT) ? sw_strobe : tmr_tick);
    assign flip     = int_ev || (en && !is_int && sw_toggle);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_OFF:  if (en) state_d = PH_LOW;
            PH_LOW:  if (!en) state_d = PH_OFF;
                     else if (flip) state_d = PH_HIGH;
            PH_HIGH: if (!en) state_d = PH_OFF;
                     else if (flip) state_d = PH_LOW;
            default: state_d = PH_OFF;
        endcase
    end

    // outputs
    always_comb begin
        clk_level = (state_q == PH_HIGH);
        smp_ev    = 1'b0;
        upd_ev    = 1'b0;
        if (en) begin
            if (is_int) begin
                smp_ev = int_ev && (state_q == PH_LOW);
                upd_ev = int_ev && (state_q == PH_HIGH);
            end else if (src == SRC_EXT_RISE) begin
                smp_ev = ext_rise;
                upd_ev = ext_fall;
            end else begin
                smp_ev = ext_fall;
                upd_ev = ext_rise;
            end
        end
    end

    assert_toggle_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && is_int && sw_toggle && !int_ev && state_q != PH_OFF) |=> $stable(clk_level));
    assert_off_clock_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !clk_level);
endmodule

// File: rtl/ser_edge_count.sv
module ser_edge_count #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             smp_ev,
    input  logic             upd_ev,
    input  logic             flag_clr,
    input  logic             irq_en,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             flag,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic ev;
    assign ev   = smp_ev | upd_ev;
    assign wrap = ev && (cnt == CNT_MAX);
    assign irq  = flag & irq_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  cnt <= '0;
        else if (!en) cnt <= '0;
        else if (ev)  cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag <= 1'b0;
        else if (wrap)     flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ev) |=> cnt == CNT_W'($past(cnt) + 1'b1));
    assert_wrap_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ev && cnt == CNT_MAX) |=> flag);
    assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);
    assert_off_count_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> cnt == '0);
endmodule

// File: rtl/ser_shift_reg.sv
module ser_shift_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              smp_ev,
    input  logic              upd_ev,
    input  logic              di_s,
    input  logic              wrap,
    output logic [DATA_W-1:0] shreg,
    output logic              do_q,
    output logic [DATA_W-1:0] buf_q
);
    logic [DATA_W-1:0] shreg_d;

    always_comb begin
        if (wr)          shreg_d = wdata;
        else if (smp_ev) shreg_d = {shreg[DATA_W-2:0], di_s};
        else             shreg_d = shreg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            buf_q <= '0;
            do_q  <= 1'b0;
        end else begin
            shreg <= shreg_d;
            if (wrap)        buf_q <= shreg_d;
            if (wr)          do_q  <= wdata[DATA_W-1];
            else if (upd_ev) do_q  <= shreg[DATA_W-1];
        end
    end

    assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_ev && !wr) |=> $stable(do_q));
    assert_buf_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(buf_q));
endmodule

// File: rtl/ser_shift_unit.sv
module ser_shift_unit
    import ser_shift_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(2 * DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        wire_mode,
    input  logic [1:0]        clk_src,
    input  logic              irq_en,
    input  logic              dat_wr,
    input  logic [DATA_W-1:0] dat_wdata,
    input  logic              flag_clr,
    input  logic              sw_strobe,
    input  logic              sw_toggle,
    input  logic              tmr_tick,
    input  logic              sck_in,
    input  logic              di_in,
    output logic [DATA_W-1:0] dat_q,
    output logic [DATA_W-1:0] buf_q,
    output logic [CNT_W-1:0]  edge_cnt,
    output logic              ovf_flag,
    output logic              irq,
    output logic              do_o,
    output logic              sck_o,
    output logic              sda_pull_low,
    output logic              scl_pull_low
);
    logic en, three_w, two_w;
    logic smp_ev, upd_ev, clk_level, di_s, wrap, do_q;

    assign en      = (wire_mode != 2'd0);
    assign three_w = (wire_mode == 2'd1);
    assign two_w   = wire_mode[1];

    ser_clk_phase #(.SYNC_STAGES(SYNC_STAGES)) u_phase (
        .clk(clk), .rst_n(rst_n), .en(en), .src(clk_src),
        .sw_strobe(sw_strobe), .tmr_tick(tmr_tick), .sw_toggle(sw_toggle),
        .sck_pin(sck_in), .di_pin(di_in),
        .smp_ev(smp_ev), .upd_ev(upd_ev), .clk_level(clk_level), .di_s(di_s)
    );

    ser_edge_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .en(en), .smp_ev(smp_ev), .upd_ev(upd_ev),
        .flag_clr(flag_clr), .irq_en(irq_en),
        .cnt(edge_cnt), .wrap(wrap), .flag(ovf_flag), .irq(irq)
    );

    ser_shift_reg #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .wr(dat_wr), .wdata(dat_wdata),
        .smp_ev(smp_ev), .upd_ev(upd_ev), .di_s(di_s), .wrap(wrap),
        .shreg(dat_q), .do_q(do_q), .buf_q(buf_q)
    );

    // line drivers
    assign do_o         = three_w ? do_q : 1'b1;
    assign sck_o        = three_w ? clk_level : 1'b0;
    assign sda_pull_low = two_w & ~do_q;
    assign scl_pull_low = two_w & ~clk_level;

    assert_2w_lines_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        two_w |-> (do_o && !sck_o));
    assert_off_lines_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (do_o && !sda_pull_low && !scl_pull_low));
endmodule

// File: tb/ser_shift_unit_test.sv
module ser_shift_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] wire_mode = 2'd0;
    logic [1:0] clk_src = 2'd0;
    logic       irq_en = 1'b1;
    logic       dat_wr = 1'b0;
    logic [7:0] dat_wdata = 8'h00;
    logic       flag_clr = 1'b0;
    logic       sw_strobe = 1'b0;
    logic       sw_toggle = 1'b0;
    logic       tmr_tick = 1'b0;
    logic       sck_in = 1'b0;
    logic       di_in = 1'b0;
    logic [7:0] dat_q, buf_q;
    logic [3:0] edge_cnt;
    logic       ovf_flag, irq, do_o, sck_o, sda_pull_low, scl_pull_low;

    int total = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ser_shift_unit uut (
        .clk(clk), .rst_n(rst_n), .wire_mode(wire_mode), .clk_src(clk_src),
        .irq_en(irq_en), .dat_wr(dat_wr), .dat_wdata(dat_wdata), .flag_clr(flag_clr),
        .sw_strobe(sw_strobe), .sw_toggle(sw_toggle), .tmr_tick(tmr_tick),
        .sck_in(sck_in), .di_in(di_in), .dat_q(dat_q), .buf_q(buf_q),
        .edge_cnt(edge_cnt), .ovf_flag(ovf_flag), .irq(irq), .do_o(do_o),
        .sck_o(sck_o), .sda_pull_low(sda_pull_low), .scl_pull_low(scl_pull_low)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    // one shift-clock edge from the current source
    task automatic clk_edge(input bit sample);
        case (clk_src)
            2'd0: pulse(sw_strobe);
            2'd1: pulse(tmr_tick);
            2'd2: sck_in = sample;
            default: sck_in = !sample;
        endcase
        idle(6);
    endtask

    task automatic configure(input logic [1:0] mode, input logic [1:0] src);
        wire_mode = 2'd0;
        idle(2);
        clk_src = src;
        sck_in = (src == 2'd3);
        idle(6);
        pulse(flag_clr);
        wire_mode = mode;
        idle(3);
    endtask

    task automatic transfer(input logic [1:0] mode, input logic [1:0] src,
                            input logic [7:0] tx, input logic [7:0] rx);
        wire_mode = 2'd0;
        idle(2);
        dat_wdata = tx;
        pulse(dat_wr);
        configure(mode, src);
        check("R7 counter cleared before transfer", edge_cnt, 0);
        for (int i = 0; i < 8; i++) begin
            di_in = rx[7-i];
            idle(4);
            if (mode == 2'd1) check("R3 do_o before sample edge", do_o, tx[7-i]);
            else              check("R8 sda_pull_low before sample edge", sda_pull_low, !tx[7-i]);
            clk_edge(1'b1);
            if (mode == 2'd1) check("R3 do_o holds across sample edge", do_o, tx[7-i]);
            else if (src < 2'd2) check("R8 scl released after sample edge", scl_pull_low, 0);
            if (i == 7) begin
                check("R5 count after 15 edges", edge_cnt, 15);
                check("R5 flag clear before 16th edge", ovf_flag, 0);
            end
            clk_edge(1'b0);
        end
        check("R5 flag after 16 edges", ovf_flag, 1);
        check("R5 counter wrapped", edge_cnt, 0);
        check("R5 buffer holds byte", buf_q, rx);
        check("R2 shift register holds byte", dat_q, rx);
        check("R6 irq with enable", irq, 1);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // reset state
        check("R7 reset dat_q", dat_q, 0);
        check("R7 reset buf_q", buf_q, 0);
        check("R7 reset edge_cnt", edge_cnt, 0);
        check("R7 reset flag", ovf_flag, 0);
        check("R7 reset irq", irq, 0);
        check("R7 reset do_o", do_o, 1);
        check("R7 reset pulls", {sda_pull_low, scl_pull_low, sck_o}, 0);

        // host write (R1)
        dat_wdata = 8'hB4;
        pulse(dat_wr);
        check("R1 write visible on dat_q", dat_q, 8'hB4);
        wire_mode = 2'd1;
        idle(3);
        check("R1 write sets output bit", do_o, 1);
        wire_mode = 2'd0;
        idle(2);

        // mode off ignores events (R7)
        clk_src = 2'd0;
        repeat (5) clk_edge(1'b1);
        check("R7 off ignores strobes count", edge_cnt, 0);
        check("R7 off keeps shift register", dat_q, 8'hB4);
        check("R7 off keeps do_o high", do_o, 1);

        // every source, several patterns, three-wire
        for (int s = 0; s < 4; s++) begin
            transfer(2'd1, 2'(s), 8'hA5, 8'h3C);
            transfer(2'd1, 2'(s), 8'hFF, 8'h00);
            transfer(2'd1, 2'(s), 8'h00, 8'hFF);
            transfer(2'd1, 2'(s), 8'h81, 8'h7E);
        end

        // sweep of all receive bytes, software strobe (R2, R4)
        for (int b = 0; b < 256; b++) transfer(2'd1, 2'd0, ~8'(b), 8'(b));

        // two-wire transfers, data in from di_in (R10, R8)
        transfer(2'd2, 2'd0, 8'hC3, 8'h96);
        transfer(2'd3, 2'd1, 8'h5A, 8'hE1);
        transfer(2'd2, 2'd3, 8'h17, 8'h8B);
        check("R10 two-wire receive via di_in", buf_q, 8'h8B);
        check("R8 two-wire do_o high", do_o, 1);
        check("R8 two-wire sck_o low", sck_o, 0);

        // interrupt enable and clear (R6)
        irq_en = 1'b0;
        idle(1);
        check("R6 irq masked", irq, 0);
        check("R6 flag still set", ovf_flag, 1);
        irq_en = 1'b1;
        idle(1);
        pulse(flag_clr);
        check("R6 flag cleared", ovf_flag, 0);
        check("R6 irq cleared", irq, 0);

        // set wins over clear (R6)
        configure(2'd1, 2'd0);
        repeat (15) clk_edge(1'b1);
        sw_strobe = 1'b1;
        flag_clr = 1'b1;
        @(negedge clk);
        sw_strobe = 1'b0;
        flag_clr = 1'b0;
        idle(1);
        check("R6 wrap wins over clear", ovf_flag, 1);

        // unselected source ignored (R4)
        configure(2'd1, 2'd0);
        pulse(tmr_tick);
        idle(2);
        check("R4 timer ignored with strobe source", edge_cnt, 0);
        clk_edge(1'b1);
        check("R4 strobe counted", edge_cnt, 1);
        configure(2'd1, 2'd1);
        pulse(sw_strobe);
        idle(2);
        check("R4 strobe ignored with timer source", edge_cnt, 0);
        repeat (5) clk_edge(1'b1);
        check("R5 five edges counted", edge_cnt, 5);

        // software toggle (R9)
        configure(2'd1, 2'd2);
        check("R9 clock output starts low", sck_o, 0);
        pulse(sw_toggle);
        idle(1);
        check("R9 toggle raises clock", sck_o, 1);
        check("R9 toggle not counted", edge_cnt, 0);
        pulse(sw_toggle);
        idle(1);
        check("R9 toggle lowers clock", sck_o, 0);
        configure(2'd1, 2'd0);
        pulse(sw_toggle);
        idle(1);
        check("R9 toggle ignored with internal source", sck_o, 0);
        check("R9 toggle ignored count", edge_cnt, 0);

        wire_mode = 2'd0;
        idle(2);
        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 180000 && !finished) begin
            finished = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule